// File: doc/BRIEF.md
# Indirect Table Access Port

This block sits between a host register interface and a 128-entry by 8-bit table that the host cannot address directly. The host sees three things: an address register with an auto-increment enable, a data register, and two self-clearing command flags, one for write and one for read. To store a byte, the host loads the address and the data, then raises the write command. The port copies the data register into the table and drops the write flag when the copy is done. A read command fetches the addressed entry into the data register in the same way.

With auto-increment on, the address advances after every completed access. A whole table can then be loaded or dumped by zeroing the address once and repeating "put data, command, poll until clear" for each entry. With auto-increment off, the address stays where the host put it, which gives random access. Host bus decoding is outside the block: each register load arrives as a one-cycle strobe with its value.

Top module: `tbl_port`

## Requirements
- R1: During and after reset, host_addr is 0, host_auto is 0, host_data is 0x00, and wr_busy and rd_busy are both low.
- R2: While no command is in progress, a cfg_we strobe loads cfg_addr into host_addr and cfg_auto into host_auto at the next clock edge, and a dat_we strobe loads dat_wdata into host_data.
- R3: A wr_set strobe seen while idle stores host_data into the table at host_addr. wr_busy reads 1 for exactly two cycles after the accepting edge and then returns to 0.
- R4: An rd_set strobe seen while idle loads the table entry at host_addr into host_data. rd_busy reads 1 for exactly two cycles, and host_data holds the entry once rd_busy is 0.
- R5: With host_auto at 1, host_addr rises by one at the edge where the busy flag clears. The access itself uses the address from before the increment.
- R6: Auto-increment wraps host_addr from 127 to 0.
- R7: With host_auto at 0, host_addr is unchanged by a completed access.
- R8: If wr_set and rd_set arrive in the same cycle, only the write is performed. rd_busy stays 0 and host_data is not reloaded from the table.
- R9: While wr_busy or rd_busy is 1, the cfg_we, dat_we, wr_set and rd_set strobes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load strobe for the address and auto-increment fields |
| cfg_addr | input | 7 | Address value to load |
| cfg_auto | input | 1 | Auto-increment enable value to load |
| dat_we | input | 1 | Load strobe for the data register |
| dat_wdata | input | 8 | Data value to load |
| wr_set | input | 1 | Write command strobe |
| rd_set | input | 1 | Read command strobe |
| host_addr | output | 7 | Current table address |
| host_auto | output | 1 | Current auto-increment enable |
| host_data | output | 8 | Data register |
| wr_busy | output | 1 | Write command flag, clears when the write completes |
| rd_busy | output | 1 | Read command flag, clears when the read completes |

## Verification
Two situations are hard to reach from the ports: host strobes that land in the middle of an access, and a read and a write requested in the same cycle. The vector walk covers the same-cycle case. It first stores one value at an address, then loads a different value into the data register and raises both commands together. If the read had won, the data register would show the old table byte. A directed test then holds address, data and read strobes high across the busy window of a write. Afterwards it reads the entry back to show that neither the late data nor the late address reached the table. The auto-increment wrap is exercised by starting writes and reads at address 127.

// File: rtl/tbl_port_pkg.sv
package tbl_port_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC  = 2'd1,
    ST_FIN  = 2'd2
  } seq_state_e;

  typedef enum logic {
    OP_WR = 1'b0,
    OP_RD = 1'b1
  } seq_op_e;
endpackage

// File: rtl/tbl_port_seq.sv
module tbl_port_seq
  import tbl_port_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_set,
  input  logic rd_set,
  output logic idle,
  output logic mem_we,
  output logic dat_load,
  output logic done,
  output logic wr_busy,
  output logic rd_busy
);
  seq_state_e state_q, state_n;
  seq_op_e    op_q, op_n;

  // next-state logic; write wins over read when both are raised
  always_comb begin
    state_n = state_q;
    op_n    = op_q;
    case (state_q)
      ST_IDLE: begin
        if (wr_set) begin
          state_n = ST_ACC;
          op_n    = OP_WR;
        end else if (rd_set) begin
          state_n = ST_ACC;
          op_n    = OP_RD;
        end
      end
      ST_ACC:  state_n = ST_FIN;
      ST_FIN:  state_n = ST_IDLE;
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= OP_WR;
    end else begin
      state_q <= state_n;
      op_q    <= op_n;
    end
  end

  assign idle     = (state_q == ST_IDLE);
  assign mem_we   = (state_q == ST_ACC) && (op_q == OP_WR);
  assign dat_load = (state_q == ST_ACC) && (op_q == OP_RD);
  assign done     = (state_q == ST_FIN);
  assign wr_busy  = !idle && (op_q == OP_WR);
  assign rd_busy  = !idle && (op_q == OP_RD);
endmodule

// File: rtl/tbl_port_regs.sv
module tbl_port_regs #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              idle,
  input  logic              done,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              cfg_auto,
  input  logic              dat_we,
  input  logic [DATA_W-1:0] dat_wdata,
  input  logic              dat_load,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] addr_q,
  output logic              auto_q,
  output logic [DATA_W-1:0] data_q
);
  localparam logic [ADDR_W-1:0] ADDR_ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  logic [ADDR_W-1:0] addr_n;
  logic [DATA_W-1:0] data_n;
  logic              auto_n;
  logic              addr_en, auto_en, data_en;
  logic              cfg_take, dat_take, step;

  assign cfg_take = idle && cfg_we;
  assign dat_take = idle && dat_we;
  assign step     = done && auto_q;

  always_comb begin
    addr_n  = addr_q;
    addr_en = 1'b0;
    if (cfg_take) begin
      addr_n  = cfg_addr;
      addr_en = 1'b1;
    end else if (step) begin
      addr_n  = addr_q + ADDR_ONE;  // wraps at the top of the range
      addr_en = 1'b1;
    end
  end

  always_comb begin
    auto_n  = cfg_auto;
    auto_en = cfg_take;
  end

  always_comb begin
    data_n  = data_q;
    data_en = 1'b0;
    if (dat_load) begin
      data_n  = rd_data;
      data_en = 1'b1;
    end else if (dat_take) begin
      data_n  = dat_wdata;
      data_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      auto_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (addr_en) addr_q <= addr_n;
      if (auto_en) auto_q <= auto_n;
      if (data_en) data_q <= data_n;
    end
  end
endmodule

// File: rtl/tbl_port_mem.sv
module tbl_port_mem #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] word_q [DEPTH];

  // one enabled register per entry; the storage is not reset
  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic sel;
    assign sel = we && (addr == ADDR_W'(g));
    always_ff @(posedge clk) begin
      if (sel) word_q[g] <= wdata;
    end
  end

  assign rdata = word_q[addr];
endmodule

// File: rtl/tbl_port.sv
module tbl_port #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic              cfg_auto,
  input  logic              dat_we,
  input  logic [DATA_W-1:0] dat_wdata,
  input  logic              wr_set,
  input  logic              rd_set,
  output logic [ADDR_W-1:0] host_addr,
  output logic              host_auto,
  output logic [DATA_W-1:0] host_data,
  output logic              wr_busy,
  output logic              rd_busy
);
  logic              idle, mem_we, dat_load, done;
  logic [DATA_W-1:0] rd_data;

  tbl_port_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_set   (wr_set),
    .rd_set   (rd_set),
    .idle     (idle),
    .mem_we   (mem_we),
    .dat_load (dat_load),
    .done     (done),
    .wr_busy  (wr_busy),
    .rd_busy  (rd_busy)
  );

  tbl_port_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .idle      (idle),
    .done      (done),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_auto  (cfg_auto),
    .dat_we    (dat_we),
    .dat_wdata (dat_wdata),
    .dat_load  (dat_load),
    .rd_data   (rd_data),
    .addr_q    (host_addr),
    .auto_q    (host_auto),
    .data_q    (host_data)
  );

  tbl_port_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .addr  (host_addr),
    .wdata (host_data),
    .rdata (rd_data)
  );
endmodule

// File: rtl/tbl_port_chk.sv
module tbl_port_chk #(
  parameter int ADDR_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_busy,
  input logic              rd_busy,
  input logic [ADDR_W-1:0] addr,
  input logic              auto_inc
);
  logic busy;
  assign busy = wr_busy || rd_busy;

  // R1: flags are low while reset is held
  assert_reset_idle_R1: assert property (@(posedge clk) !rst_n |-> !wr_busy && !rd_busy);

  // R3/R4: a command flag stays up for a second cycle
  assert_busy_two_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy);

  // R3/R4: never more than two cycles
  assert_busy_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |=> !busy);

  // R8: only one operation is ever in flight
  assert_one_op_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_busy && rd_busy));

  // R9: host strobes cannot move the address mid-access
  assert_addr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(addr) && $stable(auto_inc));

  // R5/R6: completion with auto-increment advances by one, with wrap
  assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && auto_inc |-> addr == ADDR_W'($past(addr) + 1'b1));

  // R7: completion without auto-increment keeps the address
  assert_addr_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && !auto_inc |-> $stable(addr));
endmodule

bind tbl_port tbl_port_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_busy  (wr_busy),
  .rd_busy  (rd_busy),
  .addr     (host_addr),
  .auto_inc (host_auto)
);

// File: tb/tbl_port_tb.sv
`timescale 1ns/1ps
module tbl_port_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0, cfg_auto = 1'b0, dat_we = 1'b0, wr_set = 1'b0, rd_set = 1'b0;
  logic [6:0] cfg_addr = '0;
  logic [7:0] dat_wdata = '0;
  logic [6:0] host_addr;
  logic       host_auto, wr_busy, rd_busy;
  logic [7:0] host_data;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  tbl_port u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_auto(cfg_auto),
    .dat_we(dat_we), .dat_wdata(dat_wdata), .wr_set(wr_set), .rd_set(rd_set),
    .host_addr(host_addr), .host_auto(host_auto), .host_data(host_data),
    .wr_busy(wr_busy), .rd_busy(rd_busy)
  );

  // {load_cfg, auto, addr[7], wdata[8], op[2] (1 wr, 2 rd, 3 both), exp_addr[7], exp_data[8]}
  localparam int NV = 12;
  localparam logic [33:0] VEC [NV] = '{
    {1'b1, 1'b1, 7'd0,   8'h11, 2'd1, 7'd1,   8'h11},
    {1'b0, 1'b0, 7'd0,   8'h22, 2'd1, 7'd2,   8'h22},
    {1'b1, 1'b1, 7'd127, 8'h7F, 2'd1, 7'd0,   8'h7F},
    {1'b1, 1'b0, 7'd5,   8'hA5, 2'd1, 7'd5,   8'hA5},
    {1'b0, 1'b0, 7'd0,   8'h5A, 2'd1, 7'd5,   8'h5A},
    {1'b1, 1'b0, 7'd3,   8'h44, 2'd1, 7'd3,   8'h44},
    {1'b0, 1'b0, 7'd0,   8'h33, 2'd3, 7'd3,   8'h33},
    {1'b1, 1'b0, 7'd0,   8'h00, 2'd2, 7'd0,   8'h11},
    {1'b1, 1'b1, 7'd1,   8'h00, 2'd2, 7'd2,   8'h22},
    {1'b1, 1'b0, 7'd5,   8'h00, 2'd2, 7'd5,   8'h5A},
    {1'b1, 1'b1, 7'd127, 8'h00, 2'd2, 7'd0,   8'h7F},
    {1'b1, 1'b0, 7'd3,   8'h00, 2'd2, 7'd3,   8'h33}
  };

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic load_cfg(input logic [6:0] a, input logic au);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_auto = au;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic load_data(input logic [7:0] d);
    @(negedge clk);
    dat_we = 1'b1; dat_wdata = d;
    @(negedge clk);
    dat_we = 1'b0;
  endtask

  // raise commands for one edge, then count busy cycles at negedges
  task automatic run_cmd(input bit w, input bit r, input string req);
    int n = 0;
    bit saw_rd = 1'b0, saw_wr = 1'b0;
    @(negedge clk);
    wr_set = w; rd_set = r;
    @(negedge clk);
    wr_set = 1'b0; rd_set = 1'b0;
    while ((wr_busy || rd_busy) && n < 10) begin
      saw_rd |= rd_busy;
      saw_wr |= wr_busy;
      n++;
      @(negedge clk);
    end
    check(n == 2, req, "busy length", n, 2);
    if (w) check(saw_wr && !saw_rd, req, "write flag only", {saw_wr, saw_rd}, 2'b10);
    else   check(saw_rd && !saw_wr, req, "read flag only", {saw_wr, saw_rd}, 2'b01);
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(host_addr == 0 && host_auto == 0 && host_data == 0 && !wr_busy && !rd_busy,
          "R1", "reset outputs", {host_auto, host_addr, host_data, wr_busy, rd_busy}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: register loads while idle
    load_cfg(7'd77, 1'b1);
    load_data(8'hC3);
    check(host_addr == 7'd77 && host_auto, "R2", "address load", {host_auto, host_addr}, {1'b1, 7'd77});
    check(host_data == 8'hC3, "R2", "data load", host_data, 8'hC3);

    // vector walk
    for (int i = 0; i < NV; i++) begin
      logic [33:0] v;
      string ra, rdq;
      v = VEC[i];
      if (v[33]) load_cfg(v[31:25], v[32]);
      if (v[15]) load_data(v[24:17]);
      rdq = (v[16:15] == 2'd3) ? "R8" : (v[16:15] == 2'd2) ? "R4" : "R3";
      ra  = !host_auto ? "R7" : (v[14:8] == 0) ? "R6" : "R5";
      run_cmd(v[15], v[16], rdq);
      check(host_addr == v[14:8], ra, $sformatf("vector %0d address", i), host_addr, v[14:8]);
      check(host_data == v[7:0], rdq, $sformatf("vector %0d data", i), host_data, v[7:0]);
    end

    // R9: strobes during a write are ignored
    load_cfg(7'd10, 1'b1);
    load_data(8'h66);
    @(negedge clk);
    wr_set = 1'b1;
    @(negedge clk);
    wr_set = 1'b0;
    rd_set = 1'b1; cfg_we = 1'b1; cfg_addr = 7'd50; cfg_auto = 1'b0; dat_we = 1'b1; dat_wdata = 8'h99;
    @(negedge clk);
    rd_set = 1'b0; cfg_we = 1'b0; dat_we = 1'b0;
    check(wr_busy && !rd_busy, "R9", "flags mid write", {wr_busy, rd_busy}, 2'b10);
    @(negedge clk);
    check(!wr_busy && !rd_busy, "R9", "no late read started", {wr_busy, rd_busy}, 0);
    check(host_addr == 7'd11 && host_auto, "R9", "address after ignored load", host_addr, 11);
    check(host_data == 8'h66, "R9", "data after ignored load", host_data, 8'h66);
    load_cfg(7'd10, 1'b0);
    load_data(8'h00);
    run_cmd(1'b0, 1'b1, "R4");
    check(host_data == 8'h66, "R9", "stored entry", host_data, 8'h66);

    // R1: reset in the middle of a write
    @(negedge clk);
    wr_set = 1'b1;
    @(negedge clk);
    wr_set = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check(!wr_busy && !rd_busy && host_addr == 0 && host_data == 0, "R1", "reset mid access",
          {wr_busy, rd_busy, host_addr, host_data}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule